// File: doc/BRIEF.md
# Register-Mapped I2C Bus Master

This block is the master side of an I2C bus with a small byte-wide register file. Software sets a clock divider, turns the block on, and sets the master bit, which puts a START on the bus. The first byte written to the data register after any START is sent as the address byte: seven target-address bits and a direction bit. Later writes send data bytes. In receive direction, each read of the data register returns the byte already held and starts fetching the next one. Clearing the master bit puts a STOP on the bus. A restart request in the control register makes the next address byte go out behind a repeated START.

The pins are open-drain: `scl_drive_low` and `sda_drive_low` pull the lines low when set, and `sda_in` is the resolved data line. Each bit period has four phases, and each phase lasts a number of clocks set by the divider. SDA changes only while SCL is low, except for START and STOP. Completed byte transfers set an interrupt-pending flag, which drives `irq`.

Top module: `i2cm_top`

## Requirements
- R1: After reset, every register offset 0..7 reads 0x00, `irq` is low, and both bus lines are released.
- R2: Offset 0 is the own-address register: bits 7:1 are kept and bit 0 reads 0. Offset 1 is the divider: bits 5:0 are kept. Offset 2 is control: bit 7 enable, bit 6 interrupt enable, bit 5 master, bit 4 transmit. Offset 3 is status: bit 5 bus busy, bit 1 interrupt pending, bit 0 received NACK. Offset 4 is data. Offsets 5..7 read 0x00 and ignore writes.
- R3: A control write with bit 7 clear, made while the block is enabled, is a soft reset. It returns every register to its reset value except the own address, which keeps its value.
- R4: A control write that sets the master bit sets bus busy and places a START (SDA falls while SCL is high). A control write that clears it clears bus busy, places a STOP (SDA rises while SCL is high) if the bus is held, and forgets the target address.
- R5: The first data write after a START is sent MSB first as the address byte. If it is acknowledged, received-NACK is cleared and an interrupt is raised. If it is not acknowledged, received-NACK is set and no interrupt is raised.
- R6: A later data write sends a data byte. If it is acknowledged, received-NACK is cleared and an interrupt is raised. If it is not acknowledged, received-NACK is set, a STOP follows, and the next data write goes out as an address byte after a new START.
- R7: Data-register writes made while the block is disabled cause no bus activity.
- R8: In receive direction with an address sent, a data read returns the held byte and clocks in the next byte MSB first. The master drives ACK low on the ninth clock, and an interrupt is raised when the byte completes.
- R9: A data read in master mode with no address sent, or with the transmit bit set, causes no bus activity, and the held byte becomes 0xFF.
- R10: The interrupt-pending bit is set only when both enable and interrupt enable are set, and `irq` follows it. Writing 0 to status bit 1 clears it. Writing 1 there has no effect.
- R11: Control bit 2 (restart) written as 1 while master mode is already active always reads back 0. It makes the next data write go out as an address byte after a repeated START, with no STOP in between.
- R12: With divider value D, each of the four phases of a bit lasts D+1 clocks, so SCL stays high for 2(D+1) clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data-register read has side effects) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt, high while the pending bit is set |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
A behavioural target on the open-drain wires acknowledges one address, logs written bytes, serves computed read bytes and counts START, STOP and SCL edges. The full sequence (start, address, several data bytes, restart into receive, stop) is swept over three divider values. This separates phase-length faults (R12) from protocol faults. Separate patterns exercise an unacknowledged address, an unacknowledged data byte, reads with no address or in transmit direction, and writes while disabled or with interrupts masked. Each of these corner cases can only pass when the block takes its intended branch.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
    // register offsets
    localparam int OFS_OWN = 0;
    localparam int OFS_DIV = 1;
    localparam int OFS_CTL = 2;
    localparam int OFS_STS = 3;
    localparam int OFS_DAT = 4;
    // control bits
    localparam int CB_EN = 7;
    localparam int CB_IE = 6;
    localparam int CB_MS = 5;
    localparam int CB_TX = 4;
    localparam int CB_RS = 2;
    // status bits
    localparam int SB_BB = 5;
    localparam int SB_IF = 1;
    localparam int SB_NK = 0;

    typedef enum logic [1:0] {E_IDLE, E_START, E_BIT, E_STOP} eng_st_e;
    typedef enum logic [1:0] {W_NONE, W_ADDR, W_TX, W_RX} wait_e;
endpackage

// File: rtl/i2cm_qtick.sv
`timescale 1ns/1ps
module i2cm_qtick #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_bit_eng.sv
`timescale 1ns/1ps
module i2cm_bit_eng import i2cm_pkg::*; #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             byte_req,
    input  logic             with_start,
    input  logic             rd_mode,
    input  logic [7:0]       tx_byte,
    input  logic             sda_in,
    output logic             scl_low,
    output logic             sda_low,
    output logic             done,
    output logic             nack,
    output logic [7:0]       rx_byte,
    output logic             on_bus,
    output logic             framing
);
    localparam logic [3:0] ACK_BIT = 4'd8;

    eng_st_e    st;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       smp, rdm, chain, tick;

    i2cm_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(st != E_IDLE), .div(div), .tick(tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st <= E_IDLE; ph <= '0; bitn <= '0; sh <= '0; smp <= 1'b1;
            rdm <= 1'b0; chain <= 1'b0; done <= 1'b0; nack <= 1'b0; on_bus <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                E_IDLE: begin
                    ph <= '0;
                    if (start_req) begin
                        st <= E_START; chain <= 1'b0;
                    end else if (byte_req) begin
                        sh <= tx_byte; rdm <= rd_mode; bitn <= '0;
                        chain <= with_start;
                        st <= with_start ? E_START : E_BIT;
                    end else if (stop_req) begin
                        st <= E_STOP;
                    end
                end
                E_START: if (tick) begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd3) begin
                        on_bus <= 1'b1;
                        st <= chain ? E_BIT : E_IDLE;
                    end
                end
                E_BIT: if (tick) begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd2) smp <= sda_in;
                    if (ph == 2'd3) begin
                        if (bitn == ACK_BIT) begin
                            st <= E_IDLE; done <= 1'b1; nack <= smp;
                        end else begin
                            sh <= {sh[6:0], smp};
                            bitn <= bitn + 4'd1;
                        end
                    end
                end
                E_STOP: if (tick) begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd3) begin
                        st <= E_IDLE; on_bus <= 1'b0;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // pin outputs
    always_comb begin
        scl_low = on_bus;
        sda_low = 1'b0;
        unique case (st)
            E_IDLE:  ;
            E_START: begin
                scl_low = (ph == 2'd0) ? on_bus : (ph == 2'd3);
                sda_low = ph[1];
            end
            E_BIT: begin
                scl_low = (ph == 2'd0) || (ph == 2'd3);
                sda_low = (bitn == ACK_BIT) ? rdm : (!rdm && !sh[7]);
            end
            E_STOP: begin
                scl_low = (ph == 2'd0);
                sda_low = !ph[1];
            end
            default: ;
        endcase
    end

    assign rx_byte = sh;
    assign framing = (st == E_START) || (st == E_STOP);
endmodule

// File: rtl/i2cm_top.sv
`timescale 1ns/1ps
module i2cm_top import i2cm_pkg::*; #(
    parameter int DIV_W = 6,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          irq,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    input  logic          sda_in
);
    logic [6:0]       own_adr;
    logic [DIV_W-1:0] div_q;
    logic             ien, iien, msta, mtx;
    logic             iif, rxak, ibb;
    logic [7:0]       rx_hold, tx_byte;
    logic             addr_ok, rs_pend;
    wait_e            wt;
    logic             start_req, stop_req, byte_req, with_start, rd_mode, eng_clr;
    logic             eng_done, eng_nack, eng_on_bus, eng_framing;
    logic [7:0]       eng_rx;

    wire wr_own  = bus_wr && (bus_addr == AW'(OFS_OWN));
    wire wr_div  = bus_wr && (bus_addr == AW'(OFS_DIV));
    wire wr_ctl  = bus_wr && (bus_addr == AW'(OFS_CTL));
    wire wr_sts  = bus_wr && (bus_addr == AW'(OFS_STS));
    wire wr_dat  = bus_wr && (bus_addr == AW'(OFS_DAT));
    wire rd_dat  = bus_rd && (bus_addr == AW'(OFS_DAT));
    wire soft_rst = wr_ctl && ien && !bus_wdata[CB_EN];
    wire irq_ok  = ien && iien;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_adr <= '0;
        end else if (wr_own) begin
            own_adr <= bus_wdata[7:1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            div_q <= '0; ien <= 1'b0; iien <= 1'b0; msta <= 1'b0; mtx <= 1'b0;
            iif <= 1'b0; rxak <= 1'b0; ibb <= 1'b0; rx_hold <= '0; tx_byte <= '0;
            addr_ok <= 1'b0; rs_pend <= 1'b0; wt <= W_NONE;
            start_req <= 1'b0; stop_req <= 1'b0; byte_req <= 1'b0;
            with_start <= 1'b0; rd_mode <= 1'b0;
            eng_clr <= soft_rst;
        end else begin
            start_req <= 1'b0; stop_req <= 1'b0; byte_req <= 1'b0; eng_clr <= 1'b0;
            if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
            if (wr_ctl) begin
                ien  <= bus_wdata[CB_EN];
                iien <= bus_wdata[CB_IE];
                msta <= bus_wdata[CB_MS];
                mtx  <= bus_wdata[CB_TX];
                if (bus_wdata[CB_MS]) begin
                    ibb <= 1'b1;
                    if (!msta && bus_wdata[CB_EN]) start_req <= 1'b1;
                    if (msta && bus_wdata[CB_RS]) begin
                        rs_pend <= 1'b1; addr_ok <= 1'b0;
                    end
                end else begin
                    ibb <= 1'b0; addr_ok <= 1'b0; rs_pend <= 1'b0;
                    if (msta && eng_on_bus) stop_req <= 1'b1;
                end
            end
            if (wr_sts && !bus_wdata[SB_IF]) iif <= 1'b0;
            if (wr_dat && ien && msta) begin
                byte_req   <= 1'b1;
                tx_byte    <= bus_wdata;
                rd_mode    <= 1'b0;
                with_start <= rs_pend || !eng_on_bus;
                rs_pend    <= 1'b0;
                wt         <= addr_ok ? W_TX : W_ADDR;
            end
            if (rd_dat && msta) begin
                if (addr_ok && !mtx) begin
                    byte_req <= 1'b1; rd_mode <= 1'b1; with_start <= 1'b0; wt <= W_RX;
                end else begin
                    rx_hold <= 8'hFF;
                end
            end
            if (eng_done) begin
                unique case (wt)
                    W_ADDR: begin
                        rxak <= eng_nack;
                        if (!eng_nack) begin
                            addr_ok <= 1'b1;
                            if (irq_ok) iif <= 1'b1;
                        end
                    end
                    W_TX: begin
                        rxak <= eng_nack;
                        if (eng_nack) begin
                            addr_ok <= 1'b0; stop_req <= 1'b1;
                        end else if (irq_ok) begin
                            iif <= 1'b1;
                        end
                    end
                    W_RX: begin
                        rx_hold <= eng_rx;
                        if (irq_ok) iif <= 1'b1;
                    end
                    W_NONE: ;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == AW'(OFS_OWN)) bus_rdata = {own_adr, 1'b0};
        if (bus_addr == AW'(OFS_DIV)) bus_rdata = 8'(div_q);
        if (bus_addr == AW'(OFS_CTL)) bus_rdata = {ien, iien, msta, mtx, 4'b0000};
        if (bus_addr == AW'(OFS_STS)) bus_rdata = {2'b00, ibb, 3'b000, iif, rxak};
        if (bus_addr == AW'(OFS_DAT)) bus_rdata = rx_hold;
    end

    assign irq = iif;

    i2cm_bit_eng #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(eng_clr), .div(div_q),
        .start_req(start_req), .stop_req(stop_req), .byte_req(byte_req),
        .with_start(with_start), .rd_mode(rd_mode), .tx_byte(tx_byte),
        .sda_in(sda_in), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
        .done(eng_done), .nack(eng_nack), .rx_byte(eng_rx),
        .on_bus(eng_on_bus), .framing(eng_framing)
    );
endmodule

// File: rtl/i2cm_chk.sv
`timescale 1ns/1ps
module i2cm_chk import i2cm_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       ien,
    input logic       iien,
    input logic       msta,
    input logic       ibb,
    input logic       iif,
    input logic       rxak,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [6:0] own_adr,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic       eng_framing,
    input logic       byte_req,
    input logic       stop_req,
    input logic       eng_done,
    input logic       eng_nack,
    input wait_e      wt
);
    wire ctl_w = bus_wr && (bus_addr == 3'(OFS_CTL));

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ien && iien));

    p_soft_keeps_own_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && ien && !bus_wdata[CB_EN]) |=> (own_adr == $past(own_adr)) && !ien && !msta);

    p_sda_only_frames_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && $past(!scl_drive_low) && (sda_drive_low != $past(sda_drive_low)))
        |-> eng_framing);

    p_busy_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && bus_wdata[CB_EN] && bus_wdata[CB_MS]) |=> ibb);

    p_busy_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && !bus_wdata[CB_MS] && !(ien && !bus_wdata[CB_EN])) |=> !ibb);

    p_off_no_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 3'(OFS_DAT)) && !ien) |=> !byte_req);

    p_addr_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && (wt == W_ADDR) && eng_nack && !bus_wr) |=> rxak && (iif == $past(iif)));

    p_tx_nack_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && (wt == W_TX) && eng_nack && !bus_wr) |=> stop_req && rxak);
endmodule

bind i2cm_top i2cm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ien(ien), .iien(iien), .msta(msta),
    .ibb(ibb), .iif(iif), .rxak(rxak), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .own_adr(own_adr), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .eng_framing(eng_framing), .byte_req(byte_req),
    .stop_req(stop_req), .eng_done(eng_done), .eng_nack(eng_nack), .wt(wt)
);

// File: tb/sim_i2cm_top.sv
`timescale 1ns/1ps
module sim_i2cm_top;
    localparam logic [6:0] TGT = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq, scl_drive_low, sda_drive_low;
    logic scl_w, sda_w;
    logic tgt_low = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_w = !scl_drive_low;
    assign sda_w = !(sda_drive_low || tgt_low);

    i2cm_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .sda_in(sda_w)
    );

    int n_tests = 0, n_fail = 0, cur_div = 0;

    function automatic logic [7:0] pat(int i);
        logic [7:0] t;
        t = 8'(i * 29 + 7);
        return t | 8'h80;
    endfunction

    // ---------------- behavioural target ----------------
    int start_cnt = 0, stop_cnt = 0, fall_cnt = 0, wr_idx = 0, rd_idx = 0;
    logic [7:0] rx_log [0:63];
    logic tgt_ack_wr = 1'b1;
    logic p_scl = 1'b1, p_sda = 1'b1;
    int   bitcnt = 0;
    int   mode = 0; // 0 idle, 1 addr, 2 write, 3 read
    logic [7:0] rsh = '0, txb = '0;
    logic ackbit = 1'b1, mack = 1'b1, matched = 1'b0;

    always @(scl_w or sda_w) begin
        if (scl_w === 1'b1 && p_scl === 1'b0) begin
            if (mode != 0) begin
                if (bitcnt < 8) rsh = {rsh[6:0], sda_w};
                else ackbit = sda_w;
                bitcnt = bitcnt + 1;
            end
        end else if (scl_w === 1'b0 && p_scl === 1'b1) begin
            fall_cnt = fall_cnt + 1;
            if (mode != 0 && bitcnt == 8) begin
                if (mode == 1) begin
                    matched = (rsh[7:1] == TGT);
                    tgt_low = matched;
                end else if (mode == 2) begin
                    rx_log[wr_idx % 64] = rsh;
                    wr_idx = wr_idx + 1;
                    tgt_low = tgt_ack_wr;
                end else begin
                    tgt_low = 1'b0;
                end
            end else if (mode != 0 && bitcnt == 9) begin
                tgt_low = 1'b0;
                bitcnt = 0;
                if (mode == 1) mode = matched ? (rsh[0] ? 3 : 2) : 0;
                else if (mode == 3) begin
                    mack = ackbit;
                    rd_idx = rd_idx + 1;
                end
                if (mode == 3) begin
                    txb = pat(rd_idx);
                    tgt_low = !txb[7];
                end
            end else if (mode == 3 && bitcnt < 8) begin
                tgt_low = !txb[7 - bitcnt];
            end
        end else if (sda_w !== p_sda && scl_w === 1'b1) begin
            if (sda_w === 1'b0 && p_sda === 1'b1) begin
                start_cnt = start_cnt + 1; mode = 1; bitcnt = 0;
            end else if (sda_w === 1'b1 && p_sda === 1'b0) begin
                stop_cnt = stop_cnt + 1; mode = 0; bitcnt = 0;
            end
        end
        p_scl = scl_w;
        p_sda = sda_w;
    end

    // SCL high-time monitor
    int hcnt = 0, last_hi = 0;
    always @(negedge clk) begin
        if (scl_w === 1'b1) hcnt = hcnt + 1;
        else begin
            if (hcnt != 0) last_hi = hcnt;
            hcnt = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic waitq();
        repeat (44 * (cur_div + 1) + 10) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] v;
        int s0, p0, f0, e;
        e = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 irq low", irq, 0);
        chk("R1 lines released", {scl_w, sda_w}, 2'b11);

        wr(0, 8'hFF); rd(0, v); chk("R2 own address mask", v, 8'hFE);
        wr(1, 8'hFF); rd(1, v); chk("R2 divider mask", v, 8'h3F);
        wr(5, 8'hFF); rd(5, v); chk("R2 unmapped 5", v, 0);
        rd(7, v); chk("R2 unmapped 7", v, 0);
        wr(1, 0);

        f0 = fall_cnt; s0 = start_cnt;
        wr(4, {TGT, 1'b0}); waitq();
        chk("R7 disabled write no SCL", fall_cnt, f0);
        chk("R7 disabled write no START", start_cnt, s0);

        for (int di = 0; di < 3; di++) begin
            cur_div = (di == 0) ? 0 : (di == 1) ? 2 : 5;
            wr(1, cur_div);
            wr(2, 8'hC0);
            s0 = start_cnt;
            wr(2, 8'hF0); waitq();
            rd(3, v); chk("R4 bus busy set", v, 8'h20);
            chk("R4 START placed", start_cnt, s0 + 1);

            wr(4, {TGT, 1'b0}); waitq();
            rd(3, v); chk("R5 address acked status", v, 8'h22);
            chk("R5 irq after address", irq, 1);
            chk("R12 SCL high clocks", last_hi, 2 * (cur_div + 1));
            wr(3, 8'h00); rd(3, v); chk("R10 write 0 clears pending", v, 8'h20);
            chk("R10 irq follows pending", irq, 0);
            wr(3, 8'hFF); rd(3, v); chk("R10 write 1 no effect", v, 8'h20);

            for (int k = 0; k < 4; k++) begin
                logic [7:0] b;
                b = 8'(cur_div * 16 + k * 37 + 3);
                wr(4, b); waitq();
                chk("R6 byte on bus", rx_log[(wr_idx - 1) % 64], b);
                rd(3, v); chk("R6 acked data status", v, 8'h22);
                wr(3, 0);
            end

            wr(2, 8'hF4); rd(2, v); chk("R11 restart reads 0", v, 8'hF0);
            s0 = start_cnt; p0 = stop_cnt;
            wr(4, {TGT, 1'b1}); waitq();
            chk("R11 repeated START", start_cnt, s0 + 1);
            chk("R11 no STOP before restart", stop_cnt, p0);
            rd(3, v); chk("R11 address after restart", v, 8'h22);
            wr(3, 0);

            wr(2, 8'hE0);
            rd(4, v); e++; waitq(); wr(3, 0);
            for (int j = 0; j < 3; j++) begin
                rd(4, v);
                chk("R8 received byte", v, pat(e - 1));
                e++;
                waitq();
                chk("R8 master ACK low", mack, 0);
                rd(3, v); chk("R8 irq on receive", v, 8'h22);
                wr(3, 0);
            end

            p0 = stop_cnt;
            wr(2, 8'hC0); waitq();
            chk("R4 STOP placed", stop_cnt, p0 + 1);
            rd(3, v); chk("R4 bus busy cleared", v, 8'h00);

            wr(2, 8'hF0); waitq();
            wr(4, {TGT, 1'b0}); waitq(); wr(3, 0);
            tgt_ack_wr = 1'b0; p0 = stop_cnt;
            wr(4, 8'h3C); waitq();
            rd(3, v); chk("R6 data NACK status", v, 8'h21);
            chk("R6 STOP after NACK", stop_cnt, p0 + 1);
            tgt_ack_wr = 1'b1; s0 = start_cnt;
            wr(4, {TGT, 1'b0}); waitq();
            chk("R6 next write is address with START", start_cnt, s0 + 1);
            rd(3, v); chk("R6 readdress acked", v, 8'h22);
            wr(3, 0);

            wr(2, 8'hC0); waitq();
            wr(2, 8'hF0); waitq();
            wr(4, {7'h11, 1'b0}); waitq();
            rd(3, v); chk("R5 address NACK status", v, 8'h21);
            chk("R5 no irq on NACK", irq, 0);

            f0 = fall_cnt;
            rd(4, v); rd(4, v);
            chk("R9 no address reads FF", v, 8'hFF);
            chk("R9 no address no SCL", fall_cnt, f0);
            wr(2, 8'hF4);
            wr(4, {TGT, 1'b0}); waitq(); wr(3, 0);
            f0 = fall_cnt;
            rd(4, v); rd(4, v);
            chk("R9 transmit dir reads FF", v, 8'hFF);
            chk("R9 transmit dir no SCL", fall_cnt, f0);

            wr(2, 8'hB0);
            wr(4, 8'h77); waitq();
            chk("R10 masked byte still sent", rx_log[(wr_idx - 1) % 64], 8'h77);
            rd(3, v); chk("R10 masked no pending", v, 8'h20);
            chk("R10 masked irq low", irq, 0);
            wr(2, 8'h80); waitq();

            wr(0, 8'h5B);
            wr(2, 8'h00);
            rd(0, v); chk("R3 own address kept", v, 8'h5A);
            rd(1, v); chk("R3 divider cleared", v, 0);
            rd(2, v); chk("R3 control cleared", v, 0);
            rd(3, v); chk("R3 status cleared", v, 0);
            rd(4, v); chk("R3 data cleared", v, 0);
        end
        finish_run();
    end
endmodule